// File: doc/BRIEF.md
# Single-Level Carry-Select Adder

This block adds two 64-bit operands and a carry-in. The whole operation is combinational, with no clock or reset. The word is cut into eight 8-bit slices. The lowest slice adds straight from the carry-in. Each of the seven upper slices works out two candidate results in parallel: one assumes no carry arrives at its lower boundary, the other assumes one does.

A separate carry-merge network takes the two conditional carry-outs of every slice and resolves the true carry at each slice boundary. It also produces the final carry-out. The resolved boundary carries drive seven 8-bit 2:1 multiplexers, which choose between the two candidates of each upper slice. There is only one selection level, and the carry path never passes through the sum multiplexers. Because of that, the carry-out can settle before the top sum bits do.

The block has no handshake. Operands, carry-in and results are plain combinational pins, and a new operand pair may be presented at any time.

Top module: `csel_adder64`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^64 for every operand pair and for both values of `cin`.
- R2: `cout` equals bit 64 of the exact sum `a` + `b` + `cin`.
- R3: `sum[7:0]` equals the low 8 bits of `a[7:0]` + `b[7:0]` + `cin`, formed directly without a selection stage.
- R4: For each upper slice k (bits 8k+7 down to 8k), the slice result equals `a`+`b` over those bits plus the true carry arriving at bit 8k. A carry that ripples out of a full lower slice must therefore reach the next slice.
- R5: Within any slice, the candidate that assumes an incoming carry of 1 never reports a smaller carry-out than the candidate that assumes 0. It also equals that candidate plus one.
- R6: A carry-in of 1 added to an all-ones operand and a zero operand propagates across all eight slices, giving `sum` = 0 and `cout` = 1.
- R7: The outputs follow the inputs with no storage, so a result is valid in the same cycle in which its operands are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench builds the adder with its default width of 64 and slice width of 8, which gives seven selected slices. With these values, patterns whose carries end exactly at a slice boundary come within reach. Examples are a full lowest slice plus one, and 56 ones plus one. So does a carry that runs through every boundary. Alternating bit patterns in both polarities of the carry-in drive the all-propagate case. Random operands cover the general case of mixed generate and kill slices.

// File: rtl/csel_pkg.sv
package csel_pkg;
  parameter int unsigned CSEL_WIDTH = 64;
  parameter int unsigned CSEL_SLICE = 8;
endpackage

// File: rtl/csel_base_slice.sv
module csel_base_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    s     = total[W-1:0];
    co    = total[W];
  end
endmodule

// File: rtl/csel_dual_slice.sv
module csel_dual_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic         co0,
  output logic         co1
);
  logic [W:0] t_zero;
  logic [W:0] t_one;

  always_comb begin
    t_zero = {1'b0, a} + {1'b0, b};
    t_one  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    s0     = t_zero[W-1:0];
    co0    = t_zero[W];
    s1     = t_one[W-1:0];
    co1    = t_one[W];
  end

  // R5
  always_comb begin
    candidate_step_chk: assert ({co1, s1} == {co0, s0} + {{W{1'b0}}, 1'b1})
      else $error("R5: carry-1 candidate is not carry-0 candidate plus one");
  end
endmodule

// File: rtl/csel_carry_merge.sv
module csel_carry_merge #(
  parameter int unsigned NS = 8
) (
  input  logic          base_co,
  input  logic [NS-1:1] cond_c0,
  input  logic [NS-1:1] cond_c1,
  output logic [NS-1:1] sel,
  output logic          cout
);
  logic [NS:1] bnd;

  always_comb begin
    bnd[1] = base_co;
    for (int i = 1; i < NS; i++) begin
      bnd[i+1] = cond_c0[i] | (cond_c1[i] & bnd[i]);
    end
    sel  = bnd[NS-1:1];
    cout = bnd[NS];
  end

  // R5
  always_comb begin
    for (int i = 1; i < NS; i++) begin
      cond_order_chk: assert (!(cond_c0[i] && !cond_c1[i]))
        else $error("R5: slice %0d carry-0 out exceeds carry-1 out", i);
    end
  end
endmodule

// File: rtl/csel_adder64.sv
module csel_adder64
  import csel_pkg::*;
#(
  parameter int unsigned WIDTH = CSEL_WIDTH,
  parameter int unsigned SLICE = CSEL_SLICE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NS = WIDTH / SLICE;

  logic [SLICE-1:0] lo_sum;
  logic             lo_co;
  logic [NS-1:1]    c0_vec;
  logic [NS-1:1]    c1_vec;
  logic [NS-1:1]    sel_vec;
  logic [SLICE-1:0] pre0 [NS-1:1];
  logic [SLICE-1:0] pre1 [NS-1:1];
  logic [SLICE-1:0] pick [NS-1:1];

  csel_base_slice #(.W(SLICE)) u_base (
    .a  (a[SLICE-1:0]),
    .b  (b[SLICE-1:0]),
    .cin(cin),
    .s  (lo_sum),
    .co (lo_co)
  );

  for (genvar k = 1; k < NS; k++) begin : g_slice
    csel_dual_slice #(.W(SLICE)) u_dual (
      .a  (a[k*SLICE +: SLICE]),
      .b  (b[k*SLICE +: SLICE]),
      .s0 (pre0[k]),
      .s1 (pre1[k]),
      .co0(c0_vec[k]),
      .co1(c1_vec[k])
    );
    assign pick[k] = sel_vec[k] ? pre1[k] : pre0[k];
    assign sum[k*SLICE +: SLICE] = pick[k];
  end

  assign sum[SLICE-1:0] = lo_sum;

  csel_carry_merge #(.NS(NS)) u_merge (
    .base_co(lo_co),
    .cond_c0(c0_vec),
    .cond_c1(c1_vec),
    .sel    (sel_vec),
    .cout   (cout)
  );

  // R1 R2
  always_comb begin
    sum_total_chk: assert ({cout, sum} ==
                           {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})
      else $error("R1/R2: result differs from a+b+cin");
  end

  // R3
  always_comb begin
    low_slice_chk: assert (sum[SLICE-1:0] ==
                           SLICE'(a[SLICE-1:0] + b[SLICE-1:0] + {{(SLICE-1){1'b0}}, cin}))
      else $error("R3: lowest slice mismatch");
  end
endmodule

// File: tb/csel_adder64_test.sv
module csel_adder64_test;
  logic        clk = 1'b0;
  logic [63:0] a, b, sum;
  logic        cin, cout;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  csel_adder64 uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  // fields: a, b, cin, expected sum, expected cout
  localparam int NV = 10;
  localparam logic [193:0] VEC [NV] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0, 1'b1},                       // R6
    {64'h0, 64'h0, 1'b0, 64'h0, 1'b0},
    {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 64'h0, 1'b1},
    {64'h0000_0000_0000_00FF, 64'h0, 1'b1, 64'h0000_0000_0000_0100, 1'b0},     // R4
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 1'b1},     // R2
    {64'h00FF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0100_0000_0000_0000, 1'b0},     // R4
    {64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 1'b0, 64'h0000_0000_0000_0100, 1'b0}
  };

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] ta, input logic [63:0] tb, input logic tc);
    @(posedge clk);
    a = ta; b = tb; cin = tc;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R7: idle inputs give a zero result within the same cycle
    @(negedge clk);
    check("R7 idle", {cout, sum}, 65'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][193:130], VEC[i][129:66], VEC[i][65]);
      check("R1/R2 table", {cout, sum}, {VEC[i][0], VEC[i][64:1]});
    end

    // R3: low slice wraps while carry enters bit 8
    apply(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_000F, 1'b1);
    check("R3", {57'h0, sum[7:0]}, 65'h0);
    check("R4 boundary", {64'h0, sum[8]}, 65'h1);

    // R5: flipping cin moves every upper slice by exactly its carry
    apply(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_430F, 1'b0);
    check("R5 cin0", {cout, sum}, {1'b0, 64'h2222_2222_2222_21FF});
    apply(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_430F, 1'b1);
    check("R5 cin1", {cout, sum}, {1'b0, 64'h2222_2222_2222_2200});

    // R6: all-ones plus one propagates through every slice
    apply(64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 1'b1);
    check("R6", {cout, sum}, {1'b1, 64'h0});

    // R1 R2: random operands, both carry-in values
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      logic        rc;
      logic [64:0] ref_v;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = 1'($urandom);
      ref_v = {1'b0, ra} + {1'b0, rb} + {64'h0, rc};
      apply(ra, rb, rc);
      check("R1/R2 random", {cout, sum}, ref_v);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule